// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block sets the operating mode of a small processor from a two-bit clock-source select field, an idle-enable bit and a strobe raised when the processor executes its sleep instruction. Seven modes result: one Sleep mode, in which nothing is clocked, and a Run mode and an Idle mode for each of three clock sources. The three sources are the primary clock, a secondary low-speed oscillator and the internal oscillator block. In a Run mode the CPU and the peripherals are both clocked. In an Idle mode only the peripherals are clocked.

Software changes the Run source by writing the configuration port, and the switch takes effect at once when the new source reports ready. If the source is not ready, the block stays on the old source and flags the switch as pending until the source comes up. The sleep strobe samples the idle-enable bit as it is held at that moment. A wake event brings the processor back to the Run mode for the selected source. The outputs are a mode code, CPU and peripheral clock enables and a one-hot source select, which drive clock-gating and multiplexing logic outside this block. All pins are plain level controls, and the block applies no back-pressure.

Top module: `pmm_ctrl`

## Requirements
- R1: After reset the block is in primary Run (mode code 1), with the idle-enable bit cleared, both clock enables high, `clk_sel` = 3'b001 and `switch_pending` low.
- R2: A configuration write decodes `cfg_src_sel` as follows: 2'b00 selects the primary source (index 0), 2'b01 the secondary source (index 1), and 2'b10 or 2'b11 the internal source (index 2). Bit i of `clk_sel` and of `src_ready` belongs to source index i.
- R3: In every Run mode, `cpu_clk_en` and `periph_clk_en` are both high and `clk_sel` is one-hot on the active source.
- R4: In every Idle mode, `cpu_clk_en` is low, `periph_clk_en` is high, and `clk_sel` is one-hot on the active source.
- R5: In Sleep, `cpu_clk_en`, `periph_clk_en` and `clk_sel` are all zero.
- R6: A `sleep_req` pulse in a Run mode moves the block, at the next edge, to Idle if the stored idle-enable bit is 1 and to Sleep if it is 0. It needs no other write. A write in the same cycle affects only later strobes. `sleep_req` has no effect in Idle or Sleep.
- R7: A write selecting a source whose `src_ready` bit is high in that cycle makes it the active source at that same edge, with no pending flag.
- R8: A write selecting a source that is not ready leaves the old source active and raises `switch_pending`. The switch completes at the first edge at which the requested source's ready bit is high, and `switch_pending` then falls.
- R9: `wake_evt` in Idle or Sleep returns the block, at the next edge, to the Run mode of the active source. In a Run mode it has no effect, and `sleep_req` takes priority if both are high.
- R10: `mode_code` is 0 for Sleep, 1/2/3 for primary/secondary/internal Run, and 4/5/6 for primary/secondary/internal Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_idle_en | input | 1 | Idle-enable value to store |
| cfg_src_sel | input | 2 | Clock-source select value to store |
| sleep_req | input | 1 | Pulse that marks execution of the sleep instruction |
| wake_evt | input | 1 | Wake event from interrupt logic |
| src_ready | input | 3 | Running/ready flag for each source |
| mode_code | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| clk_sel | output | 3 | One-hot clock-source select, zero in Sleep |
| switch_pending | output | 1 | Requested source not yet active |

## Verification
The bench first tries directed sequences: source writes with every select code and the target ready, which separate the correct decode of 2'b10 and 2'b11 from a wrong one. It then runs sleep strobes with the idle bit at 0 and at 1, and strobes and wakes given in the wrong mode, which show whether sampling uses the stored bit and whether events outside their mode are ignored. Writes to a source that is not ready, followed later by that source's ready bit rising, show whether the block holds the old source and completes the switch on the first ready edge. A long stretch of pseudo-random writes, strobes, wakes and ready patterns then checks that mode and source tracking stay consistent when events overlap, such as a write in the same cycle as a strobe.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int NSRC   = 3;
  localparam int SEL_W  = 2;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {SRC_PRI = 2'd0, SRC_SEC = 2'd1, SRC_INT = 2'd2} src_t;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_IDLE = 2'd1, ST_SLEEP = 2'd2} pstate_t;

  function automatic src_t decode_sel(input logic [SEL_W-1:0] sel);
    if (sel[1])      return SRC_INT;
    else if (sel[0]) return SRC_SEC;
    else             return SRC_PRI;
  endfunction

  function automatic logic [NSRC-1:0] src_onehot(input src_t s);
    logic [NSRC-1:0] v;
    v = '0;
    for (int i = 0; i < NSRC; i++) v[i] = (int'(s) == i);
    return v;
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(input pstate_t st, input src_t s);
    case (st)
      ST_RUN:  return MODE_W'(1 + int'(s));
      ST_IDLE: return MODE_W'(4 + int'(s));
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pmm_cfg_reg.sv
module pmm_cfg_reg
  import pmm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             idle_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic             idle_q,
  output src_t             wr_src
);
  assign wr_src = decode_sel(sel_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idle_q <= 1'b0;
    else if (we) idle_q <= idle_in;
  end

  a_r2_int_decode: assert property (@(posedge clk) disable iff (!rst_n)
    sel_in[1] |-> wr_src == SRC_INT);
endmodule

// File: rtl/pmm_src_tracker.sv
module pmm_src_tracker
  import pmm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  src_t            wr_src,
  input  logic [NSRC-1:0] ready,
  output src_t            act_src,
  output logic            pending
);
  src_t req_src, req_nxt;
  logic nxt_ready;

  assign req_nxt = we ? wr_src : req_src;

  always_comb begin
    nxt_ready = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (int'(req_nxt) == i) nxt_ready = ready[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_src <= SRC_PRI;
      act_src <= SRC_PRI;
    end else begin
      req_src <= req_nxt;
      if (nxt_ready) act_src <= req_nxt;
    end
  end

  assign pending = (req_src != act_src);

  a_r8_hold_unready: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !we && (ready & src_onehot(req_src)) == '0) |=> $stable(act_src));
  a_r8_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !we && (ready & src_onehot(req_src)) != '0) |=> !pending);
endmodule

// File: rtl/pmm_mode_fsm.sv
module pmm_mode_fsm
  import pmm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleep_req,
  input  logic    wake_evt,
  input  logic    idle_q,
  output pstate_t state
);
  pstate_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:  if (sleep_req) nxt = idle_q ? ST_IDLE : ST_SLEEP;
      ST_IDLE,
      ST_SLEEP: if (wake_evt) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  a_r6_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && sleep_req) |=> state != ST_RUN);
  a_r6_ignored_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && sleep_req && !wake_evt) |=> $stable(state));
  a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && wake_evt) |=> state == ST_RUN);
endmodule

// File: rtl/pmm_ctrl.sv
module pmm_ctrl
  import pmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_idle_en,
  input  logic [SEL_W-1:0]  cfg_src_sel,
  input  logic              sleep_req,
  input  logic              wake_evt,
  input  logic [NSRC-1:0]   src_ready,
  output logic [MODE_W-1:0] mode_code,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic [NSRC-1:0]   clk_sel,
  output logic              switch_pending
);
  logic    idle_q;
  src_t    wr_src, act_src;
  pstate_t state;

  pmm_cfg_reg i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idle_in(cfg_idle_en),
    .sel_in(cfg_src_sel), .idle_q(idle_q), .wr_src(wr_src)
  );

  pmm_src_tracker i_trk (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_src(wr_src),
    .ready(src_ready), .act_src(act_src), .pending(switch_pending)
  );

  pmm_mode_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .idle_q(idle_q), .state(state)
  );

  assign mode_code     = mode_of(state, act_src);
  assign cpu_clk_en    = (state == ST_RUN);
  assign periph_clk_en = (state != ST_SLEEP);
  assign clk_sel       = (state == ST_SLEEP) ? '0 : src_onehot(act_src);

  a_r3_run_gating: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (periph_clk_en && $onehot(clk_sel)));
  a_r4_idle_gating: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code >= 3'd4) |-> (!cpu_clk_en && periph_clk_en && $onehot(clk_sel)));
  a_r5_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0) |-> (!periph_clk_en && clk_sel == '0));
  a_r7_switch_now: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (src_ready & src_onehot(wr_src)) != '0) |=> !switch_pending);
  a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code != 3'd7);
endmodule

// File: tb/test_pmm_ctrl.sv
`timescale 1ns/1ps
module test_pmm_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_idle_en = 1'b0, sleep_req = 1'b0, wake_evt = 1'b0;
  logic [1:0] cfg_src_sel = 2'b00;
  logic [2:0] src_ready = 3'b111;
  logic [2:0] mode_code, clk_sel;
  logic cpu_clk_en, periph_clk_en, switch_pending;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state: st 0=run 1=idle 2=sleep
  int m_st = 0, m_idle = 0, m_req = 0, m_act = 0;

  always #2 clk = ~clk;

  pmm_ctrl i_pmm_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idle_en(cfg_idle_en),
    .cfg_src_sel(cfg_src_sel), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .src_ready(src_ready), .mode_code(mode_code), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .clk_sel(clk_sel), .switch_pending(switch_pending)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int e_mode, e_sel;
    string g;
    e_mode = (m_st == 2) ? 0 : (m_st == 0 ? 1 + m_act : 4 + m_act);
    e_sel  = (m_st == 2) ? 0 : (1 << m_act);
    g = (m_st == 0) ? "R3" : (m_st == 1 ? "R4" : "R5");
    chk("R10 mode_code", int'(mode_code), e_mode);
    chk({g, " cpu_clk_en"}, int'(cpu_clk_en), (m_st == 0) ? 1 : 0);
    chk({g, " periph_clk_en"}, int'(periph_clk_en), (m_st != 2) ? 1 : 0);
    chk({g, " clk_sel"}, int'(clk_sel), e_sel);
    chk("R8 switch_pending", int'(switch_pending), (m_req != m_act) ? 1 : 0);
  endtask

  // one clock: drive inputs, advance the model at the edge, compare after it
  task automatic step(input bit we, input bit idl, input int sel, input bit slp,
                      input bit wk, input int rdy);
    int nreq;
    cfg_we = we; cfg_idle_en = idl; cfg_src_sel = 2'(sel);
    sleep_req = slp; wake_evt = wk; src_ready = 3'(rdy);
    @(posedge clk);
    nreq = we ? ((sel >= 2) ? 2 : sel) : m_req;            // R2 decode
    if (m_st == 0) begin
      if (slp) m_st = m_idle ? 1 : 2;                       // R6
    end else if (wk) m_st = 0;                              // R9
    m_req = nreq;
    if (((rdy >> nreq) & 1) != 0) m_act = nreq;             // R7, R8
    if (we) m_idle = idl;
    @(negedge clk);
    cfg_we = 1'b0; sleep_req = 1'b0; wake_evt = 1'b0;
    compare_all();
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all();                       // R1 values under reset
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", int'(mode_code), 1);
    chk("R1 reset sel", int'(clk_sel), 1);
    compare_all();
    // R2/R7: each select code with the target ready
    step(1, 0, 1, 0, 0, 7); chk("R7 R2 sec now", int'(mode_code), 2);
    step(1, 0, 2, 0, 0, 7); chk("R2 code 10 internal", int'(mode_code), 3);
    step(1, 0, 0, 0, 0, 7);
    step(1, 0, 3, 0, 0, 7); chk("R2 code 11 internal", int'(mode_code), 3);
    // R6: sleep with idle bit 0 -> Sleep
    step(0, 0, 0, 1, 0, 7); chk("R6 R5 sleep", int'(mode_code), 0);
    step(0, 0, 0, 1, 0, 7); chk("R6 strobe ignored in sleep", int'(mode_code), 0);
    step(0, 0, 0, 0, 1, 7); chk("R9 wake to internal run", int'(mode_code), 3);
    step(0, 0, 0, 0, 1, 7); chk("R9 wake ignored in run", int'(mode_code), 3);
    // R6: set idle bit once, then strobes alone reach Idle
    step(1, 1, 0, 0, 0, 7);
    step(0, 0, 0, 1, 0, 7); chk("R6 R4 idle primary", int'(mode_code), 4);
    step(0, 0, 0, 0, 1, 7);
    step(0, 0, 0, 1, 0, 7); chk("R6 strobe only idle", int'(mode_code), 4);
    step(0, 0, 0, 1, 1, 7); chk("R9 wake over strobe in idle", int'(mode_code), 1);
    step(0, 0, 0, 1, 1, 7); chk("R9 strobe wins in run", int'(mode_code), 4);
    step(0, 0, 0, 0, 1, 7);
    // R8: secondary not ready
    step(1, 1, 1, 0, 0, 3'b101); chk("R8 pending raised", int'(switch_pending), 1);
    step(0, 0, 0, 0, 0, 3'b101); chk("R8 old source kept", int'(clk_sel), 1);
    step(0, 0, 0, 1, 0, 3'b101); chk("R8 idle on old source", int'(mode_code), 4);
    step(0, 0, 0, 0, 0, 3'b111); chk("R8 completes on ready", int'(mode_code), 5);
    step(0, 0, 0, 0, 1, 7);
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) == 0, $urandom % 2, $urandom % 4, ($urandom % 6) == 0,
           ($urandom % 5) == 0, (($urandom % 3) == 0) ? int'($urandom % 8) : 7);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule